// File: doc/BRIEF.md
# Learning CAM Address Table

This block is a content-addressable address table for a switching datapath. Each stored entry pairs a 48-bit compare key with a 32-bit associated-data word. Every entry also carries a per-entry age stamp and a valid bit. Commands come in on a synchronous port under a valid/ready handshake, and there are two kinds. A search looks up a destination key and returns the associated data and the location of the matching entry. A learn looks up a source key. If the key is absent, the learn inserts it into the lowest-numbered free location. If the key is present, the learn refreshes that entry's age stamp and leaves its key and data untouched.

Results leave one 32-bit word at a time. The consumer paces them with an advance strobe, and an active-low match flag reports whether the last command found its key. Every insertion also pushes a record into a small learned queue. An interrupt stays raised while that queue holds records, and management logic drains the queue one record at a time. A learn that misses when every location is occupied raises a table-full flag and changes nothing else.

Top module: `lcam_table`

## Requirements
- R1: After reset the block shows cmd_ready=1, match_n=1, out_valid=0, irq=0 and full_flag=0, and the age stamp is 0.
- R2: A search hit sets match_n=0 on the cycle after acceptance and presents two words. The first word is the entry's associated data. The second is the index word: bits [23:0] hold the entry index zero-extended, and bits [31:24] hold the entry's stored age stamp.
- R3: A search miss leaves match_n=1 and produces no output words (out_valid stays 0).
- R4: A learn miss with a free location writes the key and data into the lowest-numbered free location. It outputs a single index word carrying that location and the current age stamp, and leaves match_n=1.
- R5: Each learn-miss insertion pushes a record (key, data, index) into a first-in first-out learned queue. irq is high while the queue is non-empty. lq_pop removes the record at the head, and records leave in insertion order.
- R6: A learn hit does not overwrite the stored key or data. It sets the entry's age stamp to the current value, outputs a single index word, sets match_n=0 and pushes nothing into the queue.
- R7: The age stamp is an 8-bit counter that advances by one on each clock with age_tick high, and wraps from 255 to 0.
- R8: While out_valid is high and out_next is low, out_word and out_valid hold. With out_next high, the next word (or idle) appears after the following clock edge.
- R9: cmd_ready is low while result words remain or while the learned queue is full. A command held through that period is taken exactly once, when ready returns.
- R10: A learn miss with no free location sets full_flag. It writes nothing, pushes nothing and outputs no words. The next accepted command clears full_flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command present |
| cmd_op | input | 1 | 0 = search, 1 = learn |
| cmd_key | input | 48 | Compare key |
| cmd_data | input | 32 | Associated data stored by a learn |
| cmd_ready | output | 1 | Block can take a command this cycle |
| age_tick | input | 1 | Advance the age stamp |
| match_n | output | 1 | Low when the last accepted command found its key |
| full_flag | output | 1 | Last accepted command was a learn miss on a full table |
| out_valid | output | 1 | out_word holds a result word |
| out_word | output | 32 | Current result word |
| out_next | input | 1 | Consumer advance strobe |
| irq | output | 1 | Learned queue is non-empty |
| lq_pop | input | 1 | Remove the head record of the learned queue |
| lq_key | output | 48 | Key of the head record |
| lq_data | output | 32 | Data of the head record |
| lq_index | output | IDX_W | Table location of the head record |

## Verification
The hardest states to reach from the ports are a completely occupied table and a full learned queue. Both require long runs of distinct learns. In the table-full case, the stimulus drains the queue after every insertion. In the queue-full case, it deliberately skips the drain, so the ready stall and its release can be seen. The age-stamp wrap is reached by holding age_tick for hundreds of cycles before a learn hit, so that the stamp reported in the index word reads 255 and then 0. A command is also held against a pending two-word result, to show that it is taken only once.

// File: rtl/lcam_pkg.sv
package lcam_pkg;

    localparam int KEY_W   = 48;
    localparam int DATA_W  = 32;
    localparam int STAMP_W = 8;
    localparam int IDXF_W  = DATA_W - STAMP_W;

    typedef enum logic {
        OP_SEARCH = 1'b0,
        OP_LEARN  = 1'b1
    } op_e;

    typedef struct packed {
        logic [KEY_W-1:0]  key;
        logic [DATA_W-1:0] data;
        logic [IDXF_W-1:0] idx;
    } lq_rec_t;

    typedef struct packed {
        logic [1:0]        cnt;
        logic [DATA_W-1:0] w0;
        logic [DATA_W-1:0] w1;
    } result_t;

    function automatic logic [DATA_W-1:0] idx_word(input logic [STAMP_W-1:0] stamp,
                                                   input logic [IDXF_W-1:0] idx);
        return {stamp, idx};
    endfunction

endpackage

// File: rtl/lcam_store.sv
module lcam_store
    import lcam_pkg::*;
#(
    parameter int DEPTH = 64,
    parameter int IDX_W = $clog2(DEPTH)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [KEY_W-1:0]   lookup_key,
    input  logic               wr_en,
    input  logic [IDX_W-1:0]   wr_idx,
    input  logic [KEY_W-1:0]   wr_key,
    input  logic [DATA_W-1:0]  wr_data,
    input  logic [STAMP_W-1:0] wr_stamp,
    input  logic               ref_en,
    input  logic [IDX_W-1:0]   ref_idx,
    output logic               hit,
    output logic [IDX_W-1:0]   hit_idx,
    output logic [DATA_W-1:0]  hit_data,
    output logic [STAMP_W-1:0] hit_stamp,
    output logic               free,
    output logic [IDX_W-1:0]   free_idx
);

    logic [KEY_W-1:0]   key_mem   [DEPTH];
    logic [DATA_W-1:0]  data_mem  [DEPTH];
    logic [STAMP_W-1:0] stamp_mem [DEPTH];
    logic [DEPTH-1:0]   valid;
    logic [DEPTH-1:0]   hit_vec;

    always_ff @(posedge clk) begin
        if (rst) begin
            valid <= '0;
        end else begin
            if (wr_en) begin
                valid[wr_idx]     <= 1'b1;
                key_mem[wr_idx]   <= wr_key;
                data_mem[wr_idx]  <= wr_data;
                stamp_mem[wr_idx] <= wr_stamp;
            end
            if (ref_en) begin
                stamp_mem[ref_idx] <= wr_stamp;
            end
        end
    end

    for (genvar i = 0; i < DEPTH; i++) begin : g_cmp
        assign hit_vec[i] = valid[i] && (key_mem[i] == lookup_key);
    end

    // lowest-index priority over matches and over empty slots
    always_comb begin
        hit_idx  = '0;
        free_idx = '0;
        for (int i = DEPTH - 1; i >= 0; i--) begin
            if (hit_vec[i]) hit_idx = IDX_W'(i);
            if (!valid[i])  free_idx = IDX_W'(i);
        end
    end

    assign hit       = |hit_vec;
    assign free      = ~&valid;
    assign hit_data  = data_mem[hit_idx];
    assign hit_stamp = stamp_mem[hit_idx];

    // R6: an occupied location is never written again
    a_r6_no_overwrite: assert property (@(posedge clk) disable iff (rst)
        wr_en |-> !valid[wr_idx]);

    // R4: learn dedupes keys, so at most one location matches
    a_r4_unique_hit: assert property (@(posedge clk) disable iff (rst)
        $countones(hit_vec) <= 1);

endmodule

// File: rtl/lcam_lq.sv
module lcam_lq
    import lcam_pkg::*;
#(
    parameter int LQ_DEPTH = 4
) (
    input  logic    clk,
    input  logic    rst,
    input  logic    push,
    input  lq_rec_t rec_in,
    input  logic    pop,
    output lq_rec_t head,
    output logic    empty,
    output logic    full
);

    localparam int PW = (LQ_DEPTH > 1) ? $clog2(LQ_DEPTH) : 1;
    localparam int CW = $clog2(LQ_DEPTH + 1);

    lq_rec_t       mem [LQ_DEPTH];
    logic [PW-1:0] wp, rp;
    logic [CW-1:0] cnt;
    logic          do_push, do_pop;

    assign empty   = (cnt == '0);
    assign full    = (cnt == CW'(LQ_DEPTH));
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign head    = mem[rp];

    function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
        return (p == PW'(LQ_DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_ff @(posedge clk) begin
        if (rst) begin
            wp  <= '0;
            rp  <= '0;
            cnt <= '0;
        end else begin
            if (do_push) begin
                mem[wp] <= rec_in;
                wp      <= bump(wp);
            end
            if (do_pop) rp <= bump(rp);
            if (do_push && !do_pop)      cnt <= cnt + 1'b1;
            else if (do_pop && !do_push) cnt <= cnt - 1'b1;
        end
    end

    // R5: the table never pushes into a full queue
    a_r5_no_overflow: assert property (@(posedge clk) disable iff (rst)
        push |-> !full);

    a_r5_count_bound: assert property (@(posedge clk) disable iff (rst)
        cnt <= CW'(LQ_DEPTH));

endmodule

// File: rtl/lcam_table.sv
module lcam_table
    import lcam_pkg::*;
#(
    parameter int DEPTH    = 64,
    parameter int LQ_DEPTH = 4,
    localparam int IDX_W   = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cmd_valid,
    input  logic              cmd_op,
    input  logic [47:0]       cmd_key,
    input  logic [31:0]       cmd_data,
    output logic              cmd_ready,
    input  logic              age_tick,
    output logic              match_n,
    output logic              full_flag,
    output logic              out_valid,
    output logic [31:0]       out_word,
    input  logic              out_next,
    output logic              irq,
    input  logic              lq_pop,
    output logic [47:0]       lq_key,
    output logic [31:0]       lq_data,
    output logic [IDX_W-1:0]  lq_index
);

    logic [STAMP_W-1:0] stamp_q;
    logic               st_hit, st_free;
    logic [IDX_W-1:0]   st_hit_idx, st_free_idx;
    logic [DATA_W-1:0]  st_hit_data;
    logic [STAMP_W-1:0] st_hit_stamp;
    logic               lq_empty, lq_full;
    lq_rec_t            lq_head, lq_in;
    result_t            res_q, res_nxt;
    op_e                op;
    logic               accept, do_insert, do_refresh, do_full;

    always_ff @(posedge clk) begin
        if (rst)           stamp_q <= '0;
        else if (age_tick) stamp_q <= stamp_q + 1'b1;
    end

    assign op         = op_e'(cmd_op);
    assign cmd_ready  = (res_q.cnt == 2'd0) && !lq_full;
    assign accept     = cmd_valid && cmd_ready;
    assign do_insert  = accept && (op == OP_LEARN) && !st_hit && st_free;
    assign do_refresh = accept && (op == OP_LEARN) && st_hit;
    assign do_full    = accept && (op == OP_LEARN) && !st_hit && !st_free;

    lcam_store #(.DEPTH(DEPTH), .IDX_W(IDX_W)) u_store (
        .clk(clk), .rst(rst),
        .lookup_key(cmd_key),
        .wr_en(do_insert), .wr_idx(st_free_idx),
        .wr_key(cmd_key), .wr_data(cmd_data), .wr_stamp(stamp_q),
        .ref_en(do_refresh), .ref_idx(st_hit_idx),
        .hit(st_hit), .hit_idx(st_hit_idx),
        .hit_data(st_hit_data), .hit_stamp(st_hit_stamp),
        .free(st_free), .free_idx(st_free_idx)
    );

    assign lq_in = '{key: cmd_key, data: cmd_data, idx: IDXF_W'(st_free_idx)};

    lcam_lq #(.LQ_DEPTH(LQ_DEPTH)) u_lq (
        .clk(clk), .rst(rst),
        .push(do_insert), .rec_in(lq_in),
        .pop(lq_pop), .head(lq_head),
        .empty(lq_empty), .full(lq_full)
    );

    always_comb begin
        res_nxt = '0;
        if (op == OP_SEARCH) begin
            if (st_hit) begin
                res_nxt.cnt = 2'd2;
                res_nxt.w0  = st_hit_data;
                res_nxt.w1  = idx_word(st_hit_stamp, IDXF_W'(st_hit_idx));
            end
        end else if (st_hit) begin
            res_nxt.cnt = 2'd1;
            res_nxt.w0  = idx_word(stamp_q, IDXF_W'(st_hit_idx));
        end else if (st_free) begin
            res_nxt.cnt = 2'd1;
            res_nxt.w0  = idx_word(stamp_q, IDXF_W'(st_free_idx));
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            res_q     <= '0;
            match_n   <= 1'b1;
            full_flag <= 1'b0;
        end else if (accept) begin
            res_q     <= res_nxt;
            match_n   <= !st_hit;
            full_flag <= do_full;
        end else if (out_next && res_q.cnt != 2'd0) begin
            res_q.w0  <= res_q.w1;
            res_q.cnt <= res_q.cnt - 2'd1;
        end
    end

    assign out_valid = (res_q.cnt != 2'd0);
    assign out_word  = res_q.w0;
    assign irq       = !lq_empty;
    assign lq_key    = lq_head.key;
    assign lq_data   = lq_head.data;
    assign lq_index  = lq_head.idx[IDX_W-1:0];

    a_r8_hold: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_next) |=> (out_valid && $stable(out_word)));

    a_r9_result_needs_accept: assert property (@(posedge clk) disable iff (rst)
        $rose(out_valid) |-> $past(cmd_valid && cmd_ready));

    a_r3_search_miss: assert property (@(posedge clk) disable iff (rst)
        (accept && op == OP_SEARCH && !st_hit) |=> (match_n && !out_valid));

    a_r10_full_miss: assert property (@(posedge clk) disable iff (rst)
        do_full |=> (full_flag && !out_valid && $stable(irq)));

    a_r7_tick: assert property (@(posedge clk) disable iff (rst)
        age_tick |=> (stamp_q == STAMP_W'($past(stamp_q) + 1'b1)));

endmodule

// File: tb/lcam_table_test.sv
`timescale 1ns/1ps
module lcam_table_test;

    localparam int DEPTH = 64;
    localparam int IW    = $clog2(DEPTH);

    typedef struct packed {
        logic [7:0]  ticks;
        logic        op;
        logic [47:0] key;
        logic [31:0] data;
        logic        exp_mn;
        logic [1:0]  n;
        logic [31:0] w0;
        logic [31:0] w1;
        logic        push;
    } vec_t;

    localparam logic [47:0] KA = 48'h0000_AAAA_0001;
    localparam logic [47:0] KB = 48'h0000_BBBB_0002;
    localparam logic [47:0] KC = 48'h0000_CCCC_0003;
    localparam logic [47:0] KD = 48'h0000_DDDD_0004;
    localparam logic [47:0] KE = 48'h0000_EEEE_0005;

    localparam int NV = 9;
    localparam vec_t VECS [NV] = '{
        '{8'd0, 1'b0, KA, 32'h0,         1'b1, 2'd0, 32'h0,         32'h0,         1'b0},
        '{8'd0, 1'b1, KA, 32'hDA7A_0001, 1'b1, 2'd1, 32'h0000_0000, 32'h0,         1'b1},
        '{8'd0, 1'b1, KB, 32'hDA7A_0002, 1'b1, 2'd1, 32'h0000_0001, 32'h0,         1'b1},
        '{8'd0, 1'b0, KA, 32'h0,         1'b0, 2'd2, 32'hDA7A_0001, 32'h0000_0000, 1'b0},
        '{8'd3, 1'b1, KA, 32'h1111_2222, 1'b0, 2'd1, 32'h0300_0000, 32'h0,         1'b0},
        '{8'd0, 1'b0, KA, 32'h0,         1'b0, 2'd2, 32'hDA7A_0001, 32'h0300_0000, 1'b0},
        '{8'd0, 1'b0, KB, 32'h0,         1'b0, 2'd2, 32'hDA7A_0002, 32'h0000_0001, 1'b0},
        '{8'd0, 1'b1, KC, 32'hDA7A_0003, 1'b1, 2'd1, 32'h0300_0002, 32'h0,         1'b1},
        '{8'd0, 1'b0, KD, 32'h0,         1'b1, 2'd0, 32'h0,         32'h0,         1'b0}
    };

    logic        clk = 1'b0;
    logic        rst;
    logic        cmd_valid, cmd_op, cmd_ready, age_tick;
    logic [47:0] cmd_key;
    logic [31:0] cmd_data;
    logic        match_n, full_flag, out_valid, out_next, irq, lq_pop;
    logic [31:0] out_word, lq_data;
    logic [47:0] lq_key;
    logic [IW-1:0] lq_index;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    always #2.5 clk = ~clk;

    lcam_table #(.DEPTH(DEPTH), .LQ_DEPTH(4)) uut (
        .clk(clk), .rst(rst),
        .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_key(cmd_key), .cmd_data(cmd_data),
        .cmd_ready(cmd_ready), .age_tick(age_tick),
        .match_n(match_n), .full_flag(full_flag),
        .out_valid(out_valid), .out_word(out_word), .out_next(out_next),
        .irq(irq), .lq_pop(lq_pop),
        .lq_key(lq_key), .lq_data(lq_data), .lq_index(lq_index)
    );

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic tick(input int n);
        if (n > 0) begin
            age_tick = 1'b1;
            repeat (n) @(negedge clk);
            age_tick = 1'b0;
        end
    endtask

    task automatic send(input logic op, input logic [47:0] key, input logic [31:0] data);
        cmd_valid = 1'b1; cmd_op = op; cmd_key = key; cmd_data = data;
        while (!cmd_ready) @(negedge clk);
        @(negedge clk);
        cmd_valid = 1'b0;
    endtask

    task automatic advance();
        out_next = 1'b1;
        @(negedge clk);
        out_next = 1'b0;
    endtask

    task automatic pop();
        lq_pop = 1'b1;
        @(negedge clk);
        lq_pop = 1'b0;
    endtask

    // issue a command and consume its result words
    task automatic run(input string tag, input logic op, input logic [47:0] key,
                       input logic [31:0] data, input logic mn, input int n,
                       input logic [31:0] w0, input logic [31:0] w1);
        send(op, key, data);
        chk({tag, " match_n"}, 64'(match_n), 64'(mn));
        chk({tag, " out_valid"}, 64'(out_valid), 64'(n != 0));
        if (n >= 1) begin
            chk({tag, " word0"}, 64'(out_word), 64'(w0));
            advance();
        end
        if (n == 2) begin
            chk({tag, " word1"}, 64'(out_word), 64'(w1));
            advance();
        end
        if (n != 0) chk({tag, " idle after words"}, 64'(out_valid), 64'd0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; cmd_valid = 0; cmd_op = 0; cmd_key = '0; cmd_data = '0;
        age_tick = 0; out_next = 0; lq_pop = 0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        chk("R1 cmd_ready", 64'(cmd_ready), 64'd1);
        chk("R1 match_n", 64'(match_n), 64'd1);
        chk("R1 out_valid", 64'(out_valid), 64'd0);
        chk("R1 irq", 64'(irq), 64'd0);
        chk("R1 full_flag", 64'(full_flag), 64'd0);

        // vector table: R2 R3 R4 R5 R6
        for (int v = 0; v < NV; v++) begin
            tick(int'(VECS[v].ticks));
            run($sformatf("R2/R3/R4/R6 vec%0d", v), VECS[v].op, VECS[v].key, VECS[v].data,
                VECS[v].exp_mn, int'(VECS[v].n), VECS[v].w0, VECS[v].w1);
            chk($sformatf("R5 vec%0d irq", v), 64'(irq), 64'(VECS[v].push));
            if (VECS[v].push) begin
                chk($sformatf("R5 vec%0d lq_key", v), 64'(lq_key), 64'(VECS[v].key));
                chk($sformatf("R5 vec%0d lq_data", v), 64'(lq_data), 64'(VECS[v].data));
                chk($sformatf("R5 vec%0d lq_index", v), 64'(lq_index), 64'(VECS[v].w0[IW-1:0]));
                pop();
                chk($sformatf("R5 vec%0d irq drained", v), 64'(irq), 64'd0);
            end
        end

        // R8 hold, then R9 command held against a pending result
        send(1'b0, KC, 32'h0);
        chk("R8 first word", 64'(out_word), 64'hDA7A_0003);
        cmd_valid = 1'b1; cmd_op = 1'b1; cmd_key = KE; cmd_data = 32'hDA7A_0005;
        repeat (3) @(negedge clk);
        chk("R8 word held", 64'(out_word), 64'hDA7A_0003);
        chk("R8 valid held", 64'(out_valid), 64'd1);
        chk("R9 ready low while busy", 64'(cmd_ready), 64'd0);
        out_next = 1'b1;
        @(negedge clk);
        chk("R8 second word", 64'(out_word), 64'h0300_0002);
        @(negedge clk);
        out_next = 1'b0;
        chk("R9 ready back", 64'(cmd_ready), 64'd1);
        @(negedge clk);
        cmd_valid = 1'b0;
        chk("R9 held learn result", 64'(out_word), 64'h0300_0003);
        advance();
        chk("R9 taken once no extra words", 64'(out_valid), 64'd0);
        @(negedge clk);
        chk("R9 one record", 64'(lq_key), 64'(KE));
        pop();
        chk("R9 queue empty after one pop", 64'(irq), 64'd0);

        // R9 queue-full stall and R5 order: idx 4..8
        for (int i = 0; i < 4; i++)
            run($sformatf("R4 q%0d", i), 1'b1, 48'h100 + 48'(i), 32'h5000 + 32'(i),
                1'b1, 1, 32'h0300_0000 | 32'(4 + i), 32'h0);
        cmd_valid = 1'b1; cmd_op = 1'b1; cmd_key = 48'h104; cmd_data = 32'h5004;
        @(negedge clk);
        chk("R9 ready low on full queue", 64'(cmd_ready), 64'd0);
        chk("R9 no result while stalled", 64'(out_valid), 64'd0);
        pop();
        @(negedge clk);
        cmd_valid = 1'b0;
        chk("R9 stalled learn taken", 64'(out_word), 64'h0300_0008);
        advance();
        for (int i = 1; i < 5; i++) begin
            chk($sformatf("R5 order %0d", i), 64'(lq_key), 64'h100 + 64'(i));
            chk($sformatf("R5 index %0d", i), 64'(lq_index), 64'(4 + i));
            pop();
        end
        chk("R5 drained", 64'(irq), 64'd0);

        // R4 fill remaining locations 9..63 in ascending order
        for (int i = 9; i < DEPTH; i++) begin
            run($sformatf("R4 fill %0d", i), 1'b1, 48'h200 + 48'(i), 32'(i),
                1'b1, 1, 32'h0300_0000 | 32'(i), 32'h0);
            pop();
        end

        // R10 learn miss on a full table
        send(1'b1, 48'hFFFF, 32'h1);
        chk("R10 full_flag", 64'(full_flag), 64'd1);
        chk("R10 no words", 64'(out_valid), 64'd0);
        chk("R10 match_n", 64'(match_n), 64'd1);
        chk("R10 no push", 64'(irq), 64'd0);
        run("R10 search of missed key", 1'b0, 48'hFFFF, 32'h0, 1'b1, 0, 32'h0, 32'h0);
        chk("R10 flag cleared", 64'(full_flag), 64'd0);

        // R7 stamp wrap observed through refreshed index words
        tick(252);
        run("R7 stamp 255", 1'b1, KA, 32'h0, 1'b0, 1, 32'hFF00_0000, 32'h0);
        tick(1);
        run("R7 stamp wraps to 0", 1'b1, KB, 32'h0, 1'b0, 1, 32'h0000_0001, 32'h0);
        run("R6 data kept after refresh", 1'b0, KA, 32'h0, 1'b0, 2, 32'hDA7A_0001, 32'hFF00_0000);
        chk("R6 no push on hit", 64'(irq), 64'd0);

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule